// File: doc/BRIEF.md
# Sixteen-Bit Carry Skip Adder

This block is a purely combinational adder. It takes two 16-bit operands and a carry-in, and it returns a 16-bit sum and a carry-out. The operand bits are cut into ripple groups. The first group starts the chain from the external carry-in. Each later group receives the carry that leaves the group below it.

Each intermediate group has a bypass. When every bit of the group propagates, the AND of its per-bit propagate signals lets the incoming carry pass straight to the next group. The group's own ripple output is OR'd in alongside it. The lowest and highest groups are plain ripple adders with no bypass.

The width of the regular groups is a parameter. The top group takes whatever bits remain. With the defaults, the groups are bits 0–2, 3–5, 6–8, 9–11 and 12–15.

Top module: `skip_add16`

## Requirements
- R1: For every input combination, the 17-bit value {cout, sum} equals a + b + cin.
- R2: The carries entering bits 3, 6, 9 and 12 each equal the carry-out of adding the operand bits below that position together with cin. For example, a=0x0007, b=0x0001, cin=0 gives sum 0x0008.
- R3: When every bit of an intermediate group has a_i XOR b_i = 1, the group passes its incoming carry unchanged to the group above. For example, a=0x003F, b=0x0001 gives sum 0x0040.
- R4: When all sixteen bits propagate, cin travels through every group to cout. a=0xFFFF, b=0x0000, cin=1 gives sum 0x0000 and cout 1.
- R5: The carry into bit 0 is cin. a=0x0007, b=0, cin=1 gives sum 0x0008.
- R6: The top group is four bits wide (bits 12–15), and cout is the carry leaving bit 15. a=0xF000, b=0x1000 gives sum 0x0000 and cout 1.
- R7: A group containing a bit with a_i = b_i = 0 stops the carry at that bit. a=0, b=0, cin=1 gives sum 0x0001 and cout 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and the outputs. The bench changes the operands one time unit after a rising edge of its clock. It compares sum and cout with a behavioural integer sum at the following falling edge, half a period later. The stimulus consists of:
- an exhaustive sweep of the low six bits of both operands with both carry-in values;
- targeted group-boundary and full-bypass vectors;
- random operands.

// File: rtl/skip_add16.sv
module skip_add16 #(
  parameter int N  = 16,
  parameter int GW = 3
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  localparam int NG = N / GW;
  localparam int LW = N - (NG - 1) * GW;

  logic [N-1:0] p, g;
  logic [NG:0]  gc;

  assign p = a ^ b;
  assign g = a & b;

  always_comb begin
    int   lo, w;
    logic c, allp;
    sum   = '0;
    gc    = '0;
    gc[0] = cin;
    for (int k = 0; k < NG; k++) begin
      lo   = k * GW;
      w    = (k == NG - 1) ? LW : GW;
      c    = gc[k];
      allp = 1'b1;
      for (int j = 0; j < w; j++) begin
        sum[lo+j] = p[lo+j] ^ c;
        c         = g[lo+j] | (p[lo+j] & c);
        allp      = allp & p[lo+j];
      end
      if (k > 0 && k < NG - 1) gc[k+1] = c | (allp & gc[k]);
      else                     gc[k+1] = c;
    end
  end

  assign cout = gc[NG];
endmodule

// File: rtl/skip_add16_chk.sv
module skip_add16_chk #(
  parameter int N  = 16,
  parameter int GW = 3,
  parameter int NG = 5
) (
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic         cin,
  input logic [N-1:0] sum,
  input logic         cout,
  input logic [NG:0]  gc
);
  always_comb begin
    logic [N:0]   t;
    logic [N-1:0] m;
    logic         allp;
    p_sum_exact_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin}));
    p_carry_in_r5:  assert (gc[0] == cin);
    p_cout_r6:      assert (cout == gc[NG]);
    for (int k = 1; k < NG; k++) begin
      m = (N)'((1 << (k * GW)) - 1);
      t = {1'b0, a & m} + {1'b0, b & m} + {{N{1'b0}}, cin};
      p_group_carry_r2: assert (gc[k] == t[k * GW]);
    end
    for (int k = 1; k < NG - 1; k++) begin
      allp = 1'b1;
      for (int j = 0; j < GW; j++) allp = allp & (a[k*GW+j] ^ b[k*GW+j]);
      p_skip_pass_r3: assert (!allp || gc[k+1] == gc[k]);
    end
  end
endmodule

bind skip_add16 skip_add16_chk #(.N(N), .GW(GW), .NG(NG)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .gc(gc)
);

// File: tb/skip_add16_tb.sv
module skip_add16_tb;
  logic        clk = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        cin = 1'b0;
  logic [15:0] sum;
  logic        cout;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  skip_add16 u_dut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  task automatic apply(input logic [15:0] xa, input logic [15:0] xb, input logic xc, input string req);
    int exp;
    @(posedge clk);
    #1;
    a = xa; b = xb; cin = xc;
    @(negedge clk);
    exp = int'(xa) + int'(xb) + int'(xc);
    checks++;
    if ({cout, sum} != 17'(exp)) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%0d got=%h expected=%h", req, xa, xb, xc, {cout, sum}, 17'(exp));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    checks++;
    if ({cout, sum} != 17'h0) begin
      errors++;
      $display("FAIL R1 idle got=%h expected=00000", {cout, sum});
    end
    apply(16'h0007, 16'h0001, 1'b0, "R2");
    apply(16'h003F, 16'h0001, 1'b0, "R2");
    apply(16'h01FF, 16'h0001, 1'b0, "R2");
    apply(16'h0FFF, 16'h0001, 1'b0, "R2");
    apply(16'h003F, 16'h0001, 1'b0, "R3");
    apply(16'h0038, 16'h0000, 1'b0, "R3");
    apply(16'h01C7, 16'h0001, 1'b0, "R3");
    apply(16'h0E3F, 16'h0001, 1'b0, "R3");
    apply(16'h0FF8, 16'h0007, 1'b1, "R3");
    apply(16'hFFFF, 16'h0000, 1'b1, "R4");
    apply(16'hAAAA, 16'h5555, 1'b1, "R4");
    apply(16'h0007, 16'h0000, 1'b1, "R5");
    apply(16'h0000, 16'h0000, 1'b1, "R5");
    apply(16'hF000, 16'h1000, 1'b0, "R6");
    apply(16'h8000, 16'h8000, 1'b0, "R6");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R6");
    apply(16'h0000, 16'h0000, 1'b1, "R7");
    apply(16'h0FBF, 16'h0000, 1'b1, "R7");
    for (int c = 0; c < 2; c++)
      for (int x = 0; x < 64; x++)
        for (int y = 0; y < 64; y++)
          apply(16'(x) | 16'h0E00, 16'(y) | 16'h01C0, c[0], "R1");
    for (int i = 0; i < 3000; i++)
      apply(16'($urandom), 16'($urandom), 1'($urandom), "R1");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule